// File: doc/BRIEF.md
# Three-Group Interrupt Priority Encoder

This block gathers interrupt request lines arranged in three groups of falling urgency: critical, main and peripheral. The main and peripheral groups each have a mask register in which a set bit blocks its source. Every cycle the block turns the masked requests into one encoded status word. The word carries one field per group, holding the winning source of that group, and each field has its own valid flag. The block also forms a single 8-bit vector for the overall winner, with the group number in the top two bits and the source index in the low six. An interrupt request output is high whenever any group has a winner.

Each peripheral source carries a two-bit boost select that can raise it to medium or high urgency. A boosted source does not show up under its own number in the critical or main field. Instead it shows up there as a reserved code, and a reader that finds that code must take the source number from the peripheral field. The vector output already follows this redirect. Peripheral source 0 is the aggregate line of a bank of DMA tasks. When it is the reported peripheral source and a task is pending, the vector names the lowest pending task under a fourth group code.

Top module: `tri_group_irq_enc`

## Requirements
- R1: After reset the main mask holds 0x00010fff and the peripheral mask holds 0x7ffffc00. As a result main sources 0 and 5..16 and peripheral sources 1..21 are blocked, while main sources 1..3 and peripheral source 0 are open. Critical sources have no mask.
- R2: In the vector, a critical winner beats a main winner, and a main winner beats a peripheral winner.
- R3: Layout of the status word: critical code in bits 9:8 with valid in bit 10, main code in bits 20:16 with valid in bit 21, peripheral code in bits 28:24 with valid in bit 29. All other bits are 0, and a field whose group has no winner is 0.
- R4: Within the critical and main groups, and within one boost tier of the peripheral group, the lowest-numbered unmasked pending source wins.
- R5: Mask bit 16−n blocks main source n and mask bit 31−n blocks peripheral source n, where a value of 1 blocks. A write with `mask_we`=1 loads `mask_wdata` into the main mask when `mask_sel`=0 and into the peripheral mask when `mask_sel`=1. The new mask governs the outputs from the clock edge that captures the write, not before.
- R6: Boost select encoding per peripheral source n, in `peri_boost[2n+1:2n]`: 00 means normal, 01 means medium, and 1x means high. An unmasked pending high source inserts critical code 2, which competes by index with critical sources 0, 1 and 3. A masked source inserts no code.
- R7: An unmasked pending medium source inserts main code 4, which competes by index with the other main sources.
- R8: The peripheral field reports the lowest pending high source. If there is none it reports the lowest pending medium source, and failing that the lowest pending source.
- R9: `crit_req[2]` and `main_req[4]` are reserved positions and have no effect on any output.
- R10: The vector equals (group<<6)|index, with group 0 for critical, 1 for main, 2 for peripheral and 3 for DMA task. When the winning field holds critical code 2 or main code 4, the vector uses group 2 and the peripheral field's index.
- R11: When the vector resolves to peripheral source 0 and `task_pend` is nonzero, the vector becomes (3<<6)|(lowest set task bit). When `task_pend` is zero it stays at group 2, index 0.
- R12: `irq` is 1 exactly when at least one valid flag is set. When `irq` is 0, the status word and the vector are 0.
- R13: The status word, the vector and `irq` follow the request, boost and task inputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the mask registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_req | input | 4 | Critical request lines, codes 0, 1 and 3 (bit 2 reserved) |
| main_req | input | 17 | Main request lines, sources 0..16 (bit 4 reserved) |
| peri_req | input | 22 | Peripheral request lines, sources 0..21 |
| peri_boost | input | 44 | Two-bit boost select per peripheral source |
| task_pend | input | 16 | Pending DMA tasks behind peripheral source 0 |
| mask_we | input | 1 | Mask write strobe |
| mask_sel | input | 1 | Mask target: 0 main, 1 peripheral |
| mask_wdata | input | 32 | Mask write value |
| enc_status | output | 32 | Encoded per-group status word |
| irq_vector | output | 8 | Group and index of the overall winner |
| irq | output | 1 | Any group has a winner |

## Verification
The hardest state to reach is a boosted peripheral source whose reserved code sits in the critical or main field next to real sources of that group. In that state, index order decides whether the vector names the real source or redirects to the peripheral field. The bench builds these collisions directly. It pairs a high-boosted source with critical sources both above and below code 2, and a medium-boosted source with main sources both above and below code 4. It also mixes tiers, so that the peripheral field has to pick a boosted source over a lower-numbered normal one. A masked boosted source is also driven, and the bench confirms that no reserved code appears.

// File: rtl/irq3_pkg.sv
package irq3_pkg;
  // Status word field placement (software decodes these positions)
  localparam int CRIT_FW  = 2;
  localparam int MAIN_FW  = 5;
  localparam int PERI_FW  = 5;
  localparam int CRIT_LSB = 8;
  localparam int CRIT_VLD = 10;
  localparam int MAIN_LSB = 16;
  localparam int MAIN_VLD = 21;
  localparam int PERI_LSB = 24;
  localparam int PERI_VLD = 29;

  // Reserved codes that stand for boosted peripheral sources
  localparam int CRIT_BOOST_CODE = 2;
  localparam int MAIN_BOOST_CODE = 4;

  // Mask bit for source n is TOP - n
  localparam int MAIN_MASK_TOP = 16;
  localparam int PERI_MASK_TOP = 31;

  localparam int VEC_IW = 6;

  typedef enum logic [1:0] {
    GRP_CRIT = 2'd0,
    GRP_MAIN = 2'd1,
    GRP_PERI = 2'd2,
    GRP_TASK = 2'd3
  } grp_e;
endpackage

// File: rtl/irq3_lowest_pick.sv
module irq3_lowest_pick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  // Scan from the top down so the lowest set index is the last one written
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
    found = |req;
  end
endmodule

// File: rtl/irq3_mask_reg.sv
module irq3_mask_reg #(
  parameter int           HI  = 31,
  parameter int           LO  = 0,
  parameter logic [HI:LO] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [HI:LO] wdata,
  output logic [HI:LO] q
);
  logic [HI:LO] q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load) q_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RST;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(wdata)));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/irq3_peri_tiers.sv
module irq3_peri_tiers #(
  parameter int N = 22,
  parameter int W = 5
) (
  input  logic [N-1:0]   en,
  input  logic [2*N-1:0] boost,
  output logic           any_high,
  output logic           any_med,
  output logic           found,
  output logic [W-1:0]   idx
);
  localparam int TIERS = 3;  // 0 high, 1 medium, 2 all

  logic [N-1:0] tier_req [TIERS];
  logic         tier_found [TIERS];
  logic [W-1:0] tier_idx [TIERS];

  for (genvar n = 0; n < N; n++) begin : g_src
    assign tier_req[0][n] = en[n] &  boost[2*n+1];
    assign tier_req[1][n] = en[n] & ~boost[2*n+1] & boost[2*n];
    assign tier_req[2][n] = en[n];
  end

  for (genvar t = 0; t < TIERS; t++) begin : g_tier
    irq3_lowest_pick #(.N(N), .W(W)) pick_i (
      .req  (tier_req[t]),
      .found(tier_found[t]),
      .idx  (tier_idx[t])
    );
  end

  always_comb begin
    if (tier_found[0])      idx = tier_idx[0];
    else if (tier_found[1]) idx = tier_idx[1];
    else                    idx = tier_idx[2];
  end

  assign any_high = tier_found[0];
  assign any_med  = tier_found[1];
  assign found    = tier_found[2];
endmodule

// File: rtl/tri_group_irq_enc.sv
module tri_group_irq_enc
  import irq3_pkg::*;
#(
  parameter int          N_MAIN        = 17,
  parameter int          N_PERI        = 22,
  parameter int          N_TASK        = 16,
  parameter logic [31:0] MAIN_MASK_RST = 32'h0001_0fff,
  parameter logic [31:0] PERI_MASK_RST = 32'h7fff_fc00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            crit_req,
  input  logic [N_MAIN-1:0]     main_req,
  input  logic [N_PERI-1:0]     peri_req,
  input  logic [2*N_PERI-1:0]   peri_boost,
  input  logic [N_TASK-1:0]     task_pend,
  input  logic                  mask_we,
  input  logic                  mask_sel,
  input  logic [31:0]           mask_wdata,
  output logic [31:0]           enc_status,
  output logic [7:0]            irq_vector,
  output logic                  irq
);
  localparam int N_CRIT  = 1 << CRIT_FW;
  localparam int MAIN_HI = MAIN_MASK_TOP;
  localparam int MAIN_LO = MAIN_MASK_TOP - N_MAIN + 1;
  localparam int PERI_HI = PERI_MASK_TOP;
  localparam int PERI_LO = PERI_MASK_TOP - N_PERI + 1;
  localparam int TASK_IW = (N_TASK > 1) ? $clog2(N_TASK) : 1;

  // Mask registers (1 = source blocked)
  logic [MAIN_HI:MAIN_LO] main_mask;
  logic [PERI_HI:PERI_LO] peri_mask;

  irq3_mask_reg #(.HI(MAIN_HI), .LO(MAIN_LO),
                  .RST(MAIN_MASK_RST[MAIN_HI:MAIN_LO])) main_mask_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (mask_we & ~mask_sel),
    .wdata(mask_wdata[MAIN_HI:MAIN_LO]),
    .q    (main_mask)
  );

  irq3_mask_reg #(.HI(PERI_HI), .LO(PERI_LO),
                  .RST(PERI_MASK_RST[PERI_HI:PERI_LO])) peri_mask_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (mask_we & mask_sel),
    .wdata(mask_wdata[PERI_HI:PERI_LO]),
    .q    (peri_mask)
  );

  // Peripheral group: masking and boost tiers
  logic [N_PERI-1:0]  peri_en;
  logic               any_high, any_med, peri_found;
  logic [PERI_FW-1:0] peri_idx;

  for (genvar n = 0; n < N_PERI; n++) begin : g_peri_en
    assign peri_en[n] = peri_req[n] & ~peri_mask[PERI_MASK_TOP - n];
  end

  irq3_peri_tiers #(.N(N_PERI), .W(PERI_FW)) peri_i (
    .en      (peri_en),
    .boost   (peri_boost),
    .any_high(any_high),
    .any_med (any_med),
    .found   (peri_found),
    .idx     (peri_idx)
  );

  // Critical and main groups: reserved positions carry the boost summaries
  logic [N_CRIT-1:0] crit_eff;
  logic [N_MAIN-1:0] main_eff;

  for (genvar c = 0; c < N_CRIT; c++) begin : g_crit
    if (c == CRIT_BOOST_CODE) begin : g_rsv
      assign crit_eff[c] = any_high;
    end else begin : g_src
      assign crit_eff[c] = crit_req[c];
    end
  end

  for (genvar n = 0; n < N_MAIN; n++) begin : g_main
    if (n == MAIN_BOOST_CODE) begin : g_rsv
      assign main_eff[n] = any_med;
    end else begin : g_src
      assign main_eff[n] = main_req[n] & ~main_mask[MAIN_MASK_TOP - n];
    end
  end

  logic unused_rsv_bits;
  assign unused_rsv_bits = crit_req[CRIT_BOOST_CODE] ^ main_req[MAIN_BOOST_CODE]
                         ^ main_mask[MAIN_MASK_TOP - MAIN_BOOST_CODE];

  logic               crit_found, main_found, task_found;
  logic [CRIT_FW-1:0] crit_idx;
  logic [MAIN_FW-1:0] main_idx;
  logic [TASK_IW-1:0] task_idx;

  irq3_lowest_pick #(.N(N_CRIT), .W(CRIT_FW)) crit_pick_i (
    .req(crit_eff), .found(crit_found), .idx(crit_idx));

  irq3_lowest_pick #(.N(N_MAIN), .W(MAIN_FW)) main_pick_i (
    .req(main_eff), .found(main_found), .idx(main_idx));

  irq3_lowest_pick #(.N(N_TASK), .W(TASK_IW)) task_pick_i (
    .req(task_pend), .found(task_found), .idx(task_idx));

  // Encoded status word
  always_comb begin
    enc_status = '0;
    enc_status[CRIT_LSB +: CRIT_FW] = crit_idx;
    enc_status[CRIT_VLD]            = crit_found;
    enc_status[MAIN_LSB +: MAIN_FW] = main_idx;
    enc_status[MAIN_VLD]            = main_found;
    enc_status[PERI_LSB +: PERI_FW] = peri_idx;
    enc_status[PERI_VLD]            = peri_found;
  end

  // Combined vector with redirect of reserved codes
  logic crit_boosted, main_boosted, take_crit, take_main, take_peri;
  grp_e              vec_grp;
  logic [VEC_IW-1:0] vec_idx;

  always_comb begin
    crit_boosted = crit_found && (crit_idx == CRIT_FW'(CRIT_BOOST_CODE));
    main_boosted = main_found && (main_idx == MAIN_FW'(MAIN_BOOST_CODE));
    take_crit    = crit_found && !crit_boosted;
    take_main    = !crit_found && main_found && !main_boosted;
    take_peri    = crit_boosted || (!crit_found && main_boosted)
                || (!crit_found && !main_found && peri_found);
    vec_grp = GRP_CRIT;
    vec_idx = '0;
    if (take_crit) begin
      vec_grp = GRP_CRIT;
      vec_idx = VEC_IW'(crit_idx);
    end else if (take_main) begin
      vec_grp = GRP_MAIN;
      vec_idx = VEC_IW'(main_idx);
    end else if (take_peri) begin
      if (peri_idx == '0 && task_found) begin
        vec_grp = GRP_TASK;
        vec_idx = VEC_IW'(task_idx);
      end else begin
        vec_grp = GRP_PERI;
        vec_idx = VEC_IW'(peri_idx);
      end
    end
  end

  assign irq_vector = {vec_grp, vec_idx};
  assign irq        = crit_found | main_found | peri_found;

  // A reserved critical code must be backed by a peripheral winner (R6)
  assert_crit_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_status[CRIT_VLD] && enc_status[CRIT_LSB +: CRIT_FW] == CRIT_FW'(CRIT_BOOST_CODE))
      |-> enc_status[PERI_VLD]);

  // A reserved main code must be backed by a peripheral winner (R7)
  assert_main_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_status[MAIN_VLD] && enc_status[MAIN_LSB +: MAIN_FW] == MAIN_FW'(MAIN_BOOST_CODE))
      |-> enc_status[PERI_VLD]);

  // A main-group vector never coexists with a critical winner (R2)
  assert_main_below_crit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_vector[7:6] == GRP_MAIN) |-> !enc_status[CRIT_VLD]);

  // A task vector only stands for peripheral source 0 (R11)
  assert_task_from_src0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vector[7:6] == GRP_TASK) |->
      (enc_status[PERI_VLD] && enc_status[PERI_LSB +: PERI_FW] == '0));

  // Idle means an all-zero word and vector (R12)
  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (enc_status == '0 && irq_vector == '0));
endmodule

// File: tb/tri_group_irq_enc_tb_top.sv
module tri_group_irq_enc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  crit_req;
  logic [16:0] main_req;
  logic [21:0] peri_req;
  logic [43:0] peri_boost;
  logic [15:0] task_pend;
  logic        mask_we, mask_sel;
  logic [31:0] mask_wdata;
  logic [31:0] enc_status;
  logic [7:0]  irq_vector;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  tri_group_irq_enc dut_i (
    .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .main_req(main_req),
    .peri_req(peri_req), .peri_boost(peri_boost), .task_pend(task_pend),
    .mask_we(mask_we), .mask_sel(mask_sel), .mask_wdata(mask_wdata),
    .enc_status(enc_status), .irq_vector(irq_vector), .irq(irq)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [3:0]  c;
    logic [16:0] m;
    logic [21:0] p;
    logic [43:0] b;
    logic [15:0] t;
    logic [31:0] st;
    logic [7:0]  vec;
    logic        ir;
  } row_t;

  localparam int NROWS = 16;
  localparam row_t TBL [NROWS] = '{
    '{"R12", 4'h0, 17'h0,     22'h0,      44'h0,         16'h0,    32'h0000_0000, 8'h00, 1'b0},
    '{"R3 ", 4'h8, 17'h0,     22'h0,      44'h0,         16'h0,    32'h0000_0700, 8'h03, 1'b1},
    '{"R2 ", 4'h2, 17'h80,    22'h0,      44'h0,         16'h0,    32'h0027_0500, 8'h01, 1'b1},
    '{"R4 ", 4'h0, 17'h240,   22'h0,      44'h0,         16'h0,    32'h0026_0000, 8'h46, 1'b1},
    '{"R4 ", 4'h0, 17'h0,     22'h1020,   44'h0,         16'h0,    32'h2500_0000, 8'h85, 1'b1},
    '{"R7 ", 4'h0, 17'h0,     22'h1020,   44'h1 << 24,   16'h0,    32'h2C24_0000, 8'h8C, 1'b1},
    '{"R7 ", 4'h0, 17'h8,     22'h1020,   44'h1 << 24,   16'h0,    32'h2C23_0000, 8'h43, 1'b1},
    '{"R7 ", 4'h0, 17'h40,    22'h1000,   44'h1 << 24,   16'h0,    32'h2C24_0000, 8'h8C, 1'b1},
    '{"R6 ", 4'h8, 17'h0,     22'h100000, 44'h2 << 40,   16'h0,    32'h3400_0600, 8'h94, 1'b1},
    '{"R6 ", 4'h2, 17'h0,     22'h100000, 44'h2 << 40,   16'h0,    32'h3400_0500, 8'h01, 1'b1},
    '{"R8 ", 4'h0, 17'h0,     22'h84,     (44'h3 << 14) | (44'h1 << 4), 16'h0, 32'h2724_0600, 8'h87, 1'b1},
    '{"R11", 4'h0, 17'h0,     22'h1,      44'h0,         16'h0050, 32'h2000_0000, 8'hC4, 1'b1},
    '{"R11", 4'h0, 17'h0,     22'h1,      44'h0,         16'h0,    32'h2000_0000, 8'h80, 1'b1},
    '{"R9 ", 4'h4, 17'h10,    22'h0,      44'h0,         16'h0,    32'h0000_0000, 8'h00, 1'b0},
    '{"R10", 4'h0, 17'h0,     22'h1,      44'h2,         16'h8000, 32'h2000_0600, 8'hCF, 1'b1},
    '{"R2 ", 4'h1, 17'h10000, 22'h200000, 44'h0,         16'h0,    32'h3530_0400, 8'h00, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [16:0] m, input logic [21:0] p,
                       input logic [43:0] b, input logic [15:0] t);
    @(negedge clk);
    crit_req = c; main_req = m; peri_req = p; peri_boost = b; task_pend = t;
    #1;
  endtask

  task automatic write_mask(input logic sel, input logic [31:0] val);
    @(negedge clk);
    mask_we = 1'b1; mask_sel = sel; mask_wdata = val;
    @(negedge clk);
    mask_we = 1'b0;
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R13 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    crit_req = '0; main_req = '0; peri_req = '0; peri_boost = '0; task_pend = '0;
    mask_we = 1'b0; mask_sel = 1'b0; mask_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R12 reset idle status", enc_status, 32'h0);
    check("R12 reset idle irq", {31'b0, irq}, 32'h0);

    // R1: reset masks leave main 1..3 and peripheral 0 open
    drive(4'h0, 17'h1ffff, 22'h3fffff, 44'h0, 16'h0);
    check("R1 reset mask status", enc_status, 32'h2021_0000);
    check("R1 reset mask vector", {24'b0, irq_vector}, 32'h41);
    drive(4'h0, 17'h1ffe1, 22'h3ffffe, 44'h0, 16'h0);
    check("R1 blocked sources status", enc_status, 32'h0);
    check("R1 blocked sources irq", {31'b0, irq}, 32'h0);

    // R5: write main mask, only source 9 open; no effect before the edge
    drive(4'h0, 17'h1ffff, 22'h3fffff, 44'h0, 16'h0);
    @(negedge clk);
    mask_we = 1'b1; mask_sel = 1'b0; mask_wdata = 32'h0001_ff7f;
    #1;
    check("R5 before write edge", enc_status, 32'h2021_0000);
    @(negedge clk);
    mask_we = 1'b0;
    #1;
    check("R5 main mask applied", enc_status, 32'h2029_0000);
    write_mask(1'b1, 32'hfffb_ffff);
    check("R5 peri mask applied", enc_status, 32'h2D29_0000);
    check("R5 peri mask vector", {24'b0, irq_vector}, 32'h49);

    // R6: a masked high-boost source inserts no code
    drive(4'h0, 17'h0, 22'h100000, 44'h2 << 40, 16'h0);
    check("R6 masked boost status", enc_status, 32'h0);
    check("R6 masked boost irq", {31'b0, irq}, 32'h0);

    // R13: outputs follow inputs with no clock edge in between
    @(negedge clk);
    crit_req = 4'h8; main_req = '0; peri_req = '0; peri_boost = '0;
    #1;
    check("R13 same-cycle vector", {24'b0, irq_vector}, 32'h03);
    crit_req = 4'h0;
    #1;
    check("R13 same-cycle release", {31'b0, irq}, 32'h0);

    write_mask(1'b0, 32'h0);
    write_mask(1'b1, 32'h0);

    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i].c, TBL[i].m, TBL[i].p, TBL[i].b, TBL[i].t);
      check($sformatf("%s row %0d status", TBL[i].tag, i), enc_status, TBL[i].st);
      check($sformatf("%s row %0d vector", TBL[i].tag, i), {24'b0, irq_vector},
            {24'b0, TBL[i].vec});
      check($sformatf("%s row %0d irq", TBL[i].tag, i), {31'b0, irq}, {31'b0, TBL[i].ir});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule